// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit turns a configuration request into the active element count for a vector pipeline. A request carries the number of elements software would like to process, an element-width code and a register-grouping code. The unit works out how many elements one grouped register can hold for that width and grouping, and grants the smaller of that capacity and the request. It keeps the resulting length, the capacity and the accepted width and grouping codes in registers for downstream stages until the next request arrives.

A second, purely combinational port answers one question for operand decode: can a given architectural register index start a register group under the grouping currently in force? A group with factor G starting at register r occupies registers r to r+G-1 and acts as one register G times as wide. Only indices that are multiples of G can start a group, so a group never runs past the end of the 32-entry file.

Top module: `vcfg_unit`

## Requirements
- R1: After an accepted request, `vl_o` equals the smaller of the requested count and the capacity, so it is never larger than either.
- R2: Capacity `vlmax_o` equals G × VLEN / W, with W the element width in bits and G the grouping factor; for VLEN = 256, W = 32 and G = 8 it is 64.
- R3: Element-width code 0, 1, 2, 3 selects 8, 16, 32, 64 bits; grouping code 0, 1, 2, 3 selects factor 1, 2, 4, 8; any code from 4 to 7 in either field is unsupported.
- R4: An unsupported request sets `cfg_illegal_o`, clears `cfg_valid_o` and forces `vl_o` and `vlmax_o` to 0; a supported request clears `cfg_illegal_o` and sets `cfg_valid_o`.
- R5: Results appear on the outputs at the first rising clock edge at which `req_valid_i` is sampled high, and all outputs hold while `req_valid_i` is low, whatever the other request inputs do.
- R6: A request for 0 elements yields `vl_o` = 0 with `cfg_valid_o` = 1.
- R7: `sew_o` and `lmul_o` carry the codes of the last supported request; an unsupported request leaves them unchanged.
- R8: `chk_base_ok_o` is 1 exactly when `cfg_valid_o` is 1 and `chk_reg_i` is a multiple of the current grouping factor; it follows `chk_reg_i` in the same cycle.
- R9: After reset all outputs other than `chk_base_ok_o` are 0 and `chk_base_ok_o` is 0 for every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_avl_i | input | AVL_W (16) | Requested element count |
| req_sew_i | input | 3 | Element-width code |
| req_lmul_i | input | 3 | Grouping-factor code |
| vl_o | output | VL_W (9) | Granted element count |
| vlmax_o | output | VL_W (9) | Capacity for the current configuration |
| cfg_valid_o | output | 1 | Current configuration is supported |
| cfg_illegal_o | output | 1 | Last request used an unsupported code |
| sew_o | output | 3 | Stored element-width code |
| lmul_o | output | 3 | Stored grouping code |
| chk_reg_i | input | 5 | Register index to check |
| chk_base_ok_o | output | 1 | Index is a legal group base |

## Verification
The hardest state to reach is an unsupported request that arrives after a supported one. Only that sequence shows that the stored width and grouping codes survive while the length and capacity drop to zero. The stimulus therefore sweeps all 64 code pairs in one continuous run without reset, so every unsupported pair lands on top of the supported pair before it. Hold behaviour is reached by scrambling the request fields with the strobe low, and by issuing requests on back-to-back cycles.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SEW_E8  = 3'd0,
    SEW_E16 = 3'd1,
    SEW_E32 = 3'd2,
    SEW_E64 = 3'd3
  } sew_e;

  typedef enum logic [CODE_W-1:0] {
    LMUL_X1 = 3'd0,
    LMUL_X2 = 3'd1,
    LMUL_X4 = 3'd2,
    LMUL_X8 = 3'd3
  } lmul_e;

  // codes 0..3 are supported, 4..7 are reserved
  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c[CODE_W-1] == 1'b0;
  endfunction
endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
(
  input  logic [CODE_W-1:0] sew_i,
  input  logic [CODE_W-1:0] lmul_i,
  output logic              legal_o,
  output logic [2:0]        shamt_o
);
  logic [1:0] sew_lo, lmul_lo;

  assign sew_lo  = sew_i[1:0];
  assign lmul_lo = lmul_i[1:0];
  assign legal_o = code_ok(sew_i) && code_ok(lmul_i);

  // capacity = (VLEN/64) << (lmul + 3 - sew), range 0..6
  always_comb begin
    shamt_o = {1'b0, lmul_lo} + {1'b0, 2'd3 - sew_lo};
  end
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
  parameter int unsigned VLEN = 256,
  localparam int unsigned VL_W = $clog2(VLEN) + 1
) (
  input  logic [2:0]      shamt_i,
  output logic [VL_W-1:0] vlmax_o
);
  localparam logic [VL_W-1:0] BASE = VL_W'(VLEN / 64);

  if (VLEN < 64 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
    $error("VLEN must be a power of two of at least 64");
  end

  assign vlmax_o = BASE << shamt_i;
endmodule

// File: rtl/vcfg_grant.sv
module vcfg_grant #(
  parameter int unsigned AVL_W = 16,
  parameter int unsigned VL_W  = 9,
  localparam int unsigned CMP_W = (AVL_W > VL_W) ? AVL_W : VL_W
) (
  input  logic [AVL_W-1:0] avl_i,
  input  logic [VL_W-1:0]  vlmax_i,
  output logic [VL_W-1:0]  vl_o
);
  logic [CMP_W-1:0] avl_x, cap_x, vl_x;

  assign avl_x = CMP_W'(avl_i);
  assign cap_x = CMP_W'(vlmax_i);
  assign vl_x  = (avl_x > cap_x) ? cap_x : avl_x;
  assign vl_o  = vl_x[VL_W-1:0];
endmodule

// File: rtl/vcfg_align.sv
module vcfg_align #(
  parameter int unsigned NUM_VREGS = 32,
  localparam int unsigned REG_W  = $clog2(NUM_VREGS),
  localparam int unsigned N_GRP  = 4
) (
  input  logic [REG_W-1:0] reg_i,
  input  logic [1:0]       lmul_i,
  input  logic             en_i,
  output logic             ok_o
);
  logic [N_GRP-1:0] ok_per;

  for (genvar g = 0; g < N_GRP; g++) begin : g_fac
    logic [REG_W-1:0] msk;
    assign msk       = REG_W'((32'd1 << g) - 32'd1);
    assign ok_per[g] = (reg_i & msk) == '0;
  end

  assign ok_o = en_i && ok_per[lmul_i];
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned VLEN      = 256,
  parameter int unsigned AVL_W     = 16,
  parameter int unsigned NUM_VREGS = 32,
  localparam int unsigned VL_W     = $clog2(VLEN) + 1,
  localparam int unsigned REG_W    = $clog2(NUM_VREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [AVL_W-1:0]  req_avl_i,
  input  logic [2:0]        req_sew_i,
  input  logic [2:0]        req_lmul_i,
  output logic [VL_W-1:0]   vl_o,
  output logic [VL_W-1:0]   vlmax_o,
  output logic              cfg_valid_o,
  output logic              cfg_illegal_o,
  output logic [2:0]        sew_o,
  output logic [2:0]        lmul_o,
  input  logic [REG_W-1:0]  chk_reg_i,
  output logic              chk_base_ok_o
);
  logic             legal;
  logic [2:0]       shamt;
  logic [VL_W-1:0]  cap, grant;

  logic [VL_W-1:0]  vl_q, vlmax_q;
  logic             valid_q, illegal_q;
  logic [2:0]       sew_q, lmul_q;

  vcfg_decode i_decode (
    .sew_i   (req_sew_i),
    .lmul_i  (req_lmul_i),
    .legal_o (legal),
    .shamt_o (shamt)
  );

  vcfg_vlmax #(.VLEN(VLEN)) i_vlmax (
    .shamt_i (shamt),
    .vlmax_o (cap)
  );

  vcfg_grant #(.AVL_W(AVL_W), .VL_W(VL_W)) i_grant (
    .avl_i   (req_avl_i),
    .vlmax_i (cap),
    .vl_o    (grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q      <= '0;
      vlmax_q   <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      sew_q     <= '0;
      lmul_q    <= '0;
    end else if (req_valid_i) begin
      if (legal) begin
        vl_q      <= grant;
        vlmax_q   <= cap;
        valid_q   <= 1'b1;
        illegal_q <= 1'b0;
        sew_q     <= req_sew_i;
        lmul_q    <= req_lmul_i;
      end else begin
        // keep stored codes, drop the grant
        vl_q      <= '0;
        vlmax_q   <= '0;
        valid_q   <= 1'b0;
        illegal_q <= 1'b1;
      end
    end
  end

  vcfg_align #(.NUM_VREGS(NUM_VREGS)) i_align (
    .reg_i  (chk_reg_i),
    .lmul_i (lmul_q[1:0]),
    .en_i   (valid_q),
    .ok_o   (chk_base_ok_o)
  );

  assign vl_o          = vl_q;
  assign vlmax_o       = vlmax_q;
  assign cfg_valid_o   = valid_q;
  assign cfg_illegal_o = illegal_q;
  assign sew_o         = sew_q;
  assign lmul_o        = lmul_q;
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int unsigned VLEN  = 256,
  parameter int unsigned AVL_W = 16,
  parameter int unsigned VL_W  = 9,
  parameter int unsigned REG_W = 5,
  localparam int unsigned CMP_W = (AVL_W > VL_W) ? AVL_W : VL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [AVL_W-1:0] req_avl_i,
  input logic [2:0]       req_sew_i,
  input logic [2:0]       req_lmul_i,
  input logic [VL_W-1:0]  vl_o,
  input logic [VL_W-1:0]  vlmax_o,
  input logic             cfg_valid_o,
  input logic             cfg_illegal_o,
  input logic [2:0]       sew_o,
  input logic [2:0]       lmul_o,
  input logic [REG_W-1:0] chk_reg_i,
  input logic             chk_base_ok_o
);
  // R1
  vl_le_avl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i) && cfg_valid_o |-> CMP_W'(vl_o) <= CMP_W'($past(req_avl_i)));

  // R1
  vl_le_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= vlmax_o);

  // R2
  cap_pow2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> $countones(vlmax_o) == 1 && vlmax_o <= VL_W'(VLEN));

  // R4
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_illegal_o |-> vl_o == '0 && vlmax_o == '0 && !cfg_valid_o);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(vl_o) && $stable(vlmax_o) && $stable(cfg_valid_o)
                     && $stable(sew_o) && $stable(lmul_o));

  // R6
  avl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_avl_i == '0 && !req_sew_i[2] && !req_lmul_i[2]
    |=> vl_o == '0 && cfg_valid_o);

  // R7
  codes_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_sew_i[2] || req_lmul_i[2]) |=> $stable(sew_o) && $stable(lmul_o));

  // R8
  base_needs_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_base_ok_o |-> cfg_valid_o);
endmodule

bind vcfg_unit vcfg_unit_chk #(
  .VLEN(VLEN), .AVL_W(AVL_W), .VL_W(VL_W), .REG_W(REG_W)
) i_vcfg_unit_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_avl_i     (req_avl_i),
  .req_sew_i     (req_sew_i),
  .req_lmul_i    (req_lmul_i),
  .vl_o          (vl_o),
  .vlmax_o       (vlmax_o),
  .cfg_valid_o   (cfg_valid_o),
  .cfg_illegal_o (cfg_illegal_o),
  .sew_o         (sew_o),
  .lmul_o        (lmul_o),
  .chk_reg_i     (chk_reg_i),
  .chk_base_ok_o (chk_base_ok_o)
);

// File: tb/test_vcfg_unit.sv
module test_vcfg_unit;
  localparam int VLEN  = 256;
  localparam int AVL_W = 16;
  localparam int VL_W  = $clog2(VLEN) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [AVL_W-1:0] req_avl = '0;
  logic [2:0]       req_sew = '0;
  logic [2:0]       req_lmul = '0;
  logic [VL_W-1:0]  vl, vlmax;
  logic             cfg_valid, cfg_illegal;
  logic [2:0]       sew_q, lmul_q;
  logic [4:0]       chk_reg = '0;
  logic             base_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int e_vl = 0, e_cap = 0, e_sew = 0, e_lmul = 0;
  bit e_valid = 0, e_ill = 0;

  always #10 clk = ~clk;

  vcfg_unit #(.VLEN(VLEN), .AVL_W(AVL_W)) i_vcfg_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_avl_i(req_avl),
    .req_sew_i(req_sew), .req_lmul_i(req_lmul), .vl_o(vl), .vlmax_o(vlmax),
    .cfg_valid_o(cfg_valid), .cfg_illegal_o(cfg_illegal), .sew_o(sew_q),
    .lmul_o(lmul_q), .chk_reg_i(chk_reg), .chk_base_ok_o(base_ok)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cap_of(input int s, input int l);
    return VLEN * (1 << l) / (8 << s);
  endfunction

  // update expected state the way the requirements describe
  task automatic model(input int avl, input int s, input int l);
    if (s < 4 && l < 4) begin
      e_cap = cap_of(s, l);
      e_vl = (avl < e_cap) ? avl : e_cap;
      e_valid = 1; e_ill = 0; e_sew = s; e_lmul = l;
    end else begin
      e_vl = 0; e_cap = 0; e_valid = 0; e_ill = 1;
    end
  endtask

  task automatic check_outs(input string tag);
    check(vl == VL_W'(e_vl), {tag, " R1 vl"}, vl, e_vl);
    check(vlmax == VL_W'(e_cap), {tag, " R2 vlmax"}, vlmax, e_cap);
    check(cfg_valid == e_valid, {tag, " R4 valid"}, cfg_valid, e_valid);
    check(cfg_illegal == e_ill, {tag, " R4 illegal"}, cfg_illegal, e_ill);
    check(sew_q == 3'(e_sew), {tag, " R7 sew"}, sew_q, e_sew);
    check(lmul_q == 3'(e_lmul), {tag, " R7 lmul"}, lmul_q, e_lmul);
  endtask

  task automatic apply(input int avl, input int s, input int l);
    @(negedge clk);
    req_valid = 1'b1; req_avl = AVL_W'(avl); req_sew = 3'(s); req_lmul = 3'(l);
    @(negedge clk);
    req_valid = 1'b0;
    model(avl, s, l);
    check_outs("R5 apply");
  endtask

  task automatic sweep_regs();
    for (int r = 0; r < 32; r++) begin
      bit exp;
      chk_reg = 5'(r);
      #1;
      exp = e_valid && ((r % (1 << e_lmul)) == 0);
      check(base_ok == exp, "R8 base", base_ok, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(vl == 0 && vlmax == 0, "R9 reset len", vl, 0);
    check(!cfg_valid && !cfg_illegal, "R9 reset flags", cfg_valid, 0);
    check(sew_q == 0 && lmul_q == 0, "R9 reset codes", sew_q, 0);
    sweep_regs();
    rst_n = 1'b1;

    // R2 spot value: 32-bit elements, factor 8 -> 64
    apply(1000, 2, 3);
    check(vlmax == 64, "R2 e32 x8", vlmax, 64);

    // full code sweep, unsupported pairs land on the previous supported one (R3)
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 8; l++) begin
        int c;
        c = (s < 4 && l < 4) ? cap_of(s, l) : 8;
        apply(0, s, l);            // R6
        apply(1, s, l);
        apply(c - 1, s, l);
        apply(c, s, l);
        apply(c + 1, s, l);
        apply(65535, s, l);
      end
    end

    // R8 alignment under each factor, and under an unsupported state
    for (int l = 0; l < 4; l++) begin
      apply(5, 0, l);
      sweep_regs();
    end
    apply(5, 5, 1);
    sweep_regs();

    // R5 hold while strobe low
    apply(10, 2, 1);
    for (int k = 0; k < 4; k++) begin
      req_avl = AVL_W'(k * 77); req_sew = 3'(k); req_lmul = 3'(7 - k);
      @(negedge clk);
      check_outs("R5 hold");
    end

    // R5 back-to-back requests, each visible one edge later
    @(negedge clk);
    req_valid = 1'b1; req_avl = 16'd3; req_sew = 3'd0; req_lmul = 3'd0;
    @(negedge clk);
    model(3, 0, 0);
    check_outs("R5 b2b first");
    req_avl = 16'd500; req_sew = 3'd3; req_lmul = 3'd2;
    @(negedge clk);
    req_valid = 1'b0;
    model(500, 3, 2);
    check_outs("R5 b2b second");
    check(vl == 16, "R1 b2b cap", vl, 16);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule